// File: doc/BRIEF.md
# Encoder Holding Register with Self-Test Sequence Generator and Checker

This block is the last register in front of a serial line encoder. In normal operation it loads one character per clock from one of four upstream sources: the FIFO read port, the direct input register, the width-packer output or a special code supplied by the transmit control logic. A character is 9 bits wide: bit 8 is the data/special flag (0 = data, 1 = special) and bits 7:0 are the code.

Pulling the active-low self-test enable low turns the same register into a 9-bit maximal-length linear feedback shift register, with feedback polynomial x^9 + x^5 + 1. The stored character is the bitwise inverse of the shift-register state, so the one 9-bit value the sequence never produces is 9'h1FF. Over one 511-character period every data code appears, and so does every special code from 0x00 to 0xFE, including the violation symbols. Because the sequence is predictable, a receiver can regenerate it.

A companion sequence checker, placed on the receive side, locks to the first valid character it sees. From then on it predicts each following character, flags any character that differs from its prediction and keeps a saturating count of those differences.

Top module: `enc_bist_reg`

## Requirements
- R1: While reset is asserted and after it is released, `enc_char` is 0, `chk_locked` and `chk_mismatch` are 0 and `chk_errs` is 0.
- R2: On each clock edge with `bist_en_n` high, `enc_char` loads the source chosen by `src_sel`: 0 = `fifo_char`, 1 = `direct_char`, 2 = `packer_char`, 3 = `ctrl_char`.
- R3: On the first clock edge with `bist_en_n` low after normal operation (or after reset), `enc_char` loads the seed character. This is the inverse of the `SEED` state: 9'h1FE for the default `SEED` of 1.
- R4: On each later edge with `bist_en_n` still low, the state s is taken as ~`enc_char`. The next state is {s[7:0], s[8]^s[4]} and `enc_char` becomes its inverse. The sequence returns to the seed character after exactly 511 steps.
- R5: Within one period the 511 characters are all distinct. They include all 256 data codes (bit 8 = 0) and special codes 0x00 to 0xFE (bit 8 = 1), and never 9'h1FF.
- R6: The source inputs have no effect while `bist_en_n` is low. On the first edge with `bist_en_n` high again, `enc_char` loads the selected source.
- R7: With `chk_en_n` low, a valid `rx_char` arriving while the checker is unlocked sets `chk_locked`. That character produces no mismatch, and the checker's prediction for the next character becomes its sequence successor.
- R8: While locked, each valid character is compared with the prediction. `chk_mismatch` is high in the cycle after the edge exactly when they differ, and the prediction advances in either case. A cycle with `rx_valid` low changes neither the lock, the prediction nor the count, and leaves `chk_mismatch` low.
- R9: `chk_errs` increments once per mismatch and saturates at 2^ERR_W-1 (255 by default).
- R10: An edge with `chk_en_n` high clears `chk_locked`, `chk_mismatch` and `chk_errs`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bist_en_n | input | 1 | Self-test enable, active low |
| src_sel | input | 2 | Source select for normal loads |
| fifo_char | input | 9 | Character from the FIFO read port |
| direct_char | input | 9 | Character from the direct input register |
| packer_char | input | 9 | Character from the width packer |
| ctrl_char | input | 9 | Special character from the control logic |
| enc_char | output | 9 | Holding register contents, fed to the encoder |
| chk_en_n | input | 1 | Checker enable, active low |
| rx_valid | input | 1 | Qualifies `rx_char` |
| rx_char | input | 9 | Received character under test |
| chk_locked | output | 1 | Checker has locked to the sequence |
| chk_mismatch | output | 1 | Previous valid character differed from the prediction |
| chk_errs | output | 8 | Saturating mismatch count |

## Verification
Several rules are checked by the assertions on every cycle:
- a normal load follows its source;
- entry into self-test loads the seed;
- the running sequence never sticks and never reaches 9'h1FF;
- the checker's lock, hold, clear and saturation rules hold.

Other properties only the bench's scenarios can show, because they span the whole sequence rather than one cycle: the exact 511-step period, the coverage of every data and special code, and the exact mismatch count after an injected error and after a long run of bad characters. A reference model in the bench computes every output cycle by cycle.

// File: rtl/enc_bist_pkg.sv
package enc_bist_pkg;
   typedef enum logic [1:0] {
      SRC_FIFO   = 2'd0,
      SRC_DIRECT = 2'd1,
      SRC_PACKER = 2'd2,
      SRC_CTRL   = 2'd3
   } src_e;
endpackage

// File: rtl/enc_bist_lfsr_step.sv
module enc_bist_lfsr_step #(
   parameter int W     = 9,
   parameter int TAP_B = 5
) (
   input  logic [W-1:0] cur_char,
   output logic [W-1:0] nxt_char
);
   logic [W-1:0] cur_st;
   logic [W-1:0] nxt_st;

   assign cur_st = ~cur_char;

   // Shift toward the high end; the feedback bit enters at bit 0.
   genvar i;
   generate
      for (i = 1; i < W; i++) begin : g_shift
         assign nxt_st[i] = cur_st[i-1];
      end
   endgenerate
   assign nxt_st[0] = cur_st[W-1] ^ cur_st[TAP_B-1];

   assign nxt_char = ~nxt_st;
endmodule

// File: rtl/enc_bist_src_mux.sv
module enc_bist_src_mux
   import enc_bist_pkg::*;
#(
   parameter int W = 9
) (
   input  logic [1:0]   sel,
   input  logic [W-1:0] fifo_c,
   input  logic [W-1:0] direct_c,
   input  logic [W-1:0] packer_c,
   input  logic [W-1:0] ctrl_c,
   output logic [W-1:0] pick
);
   always_comb begin
      unique case (src_e'(sel))
         SRC_FIFO:   pick = fifo_c;
         SRC_DIRECT: pick = direct_c;
         SRC_PACKER: pick = packer_c;
         SRC_CTRL:   pick = ctrl_c;
         default:    pick = fifo_c;
      endcase
   end
endmodule

// File: rtl/enc_bist_hold_reg.sv
module enc_bist_hold_reg #(
   parameter int           W         = 9,
   parameter int           TAP_B     = 5,
   parameter logic [W-1:0] SEED_CHAR = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         bist_en_n,
   input  logic [W-1:0] src_char,
   output logic [W-1:0] hold_q,
   output logic         bist_act
);
   logic [W-1:0] step_char;

   enc_bist_lfsr_step #(.W(W), .TAP_B(TAP_B)) u_step (
      .cur_char (hold_q),
      .nxt_char (step_char)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q   <= '0;
         bist_act <= 1'b0;
      end else if (!bist_en_n) begin
         bist_act <= 1'b1;
         hold_q   <= bist_act ? step_char : SEED_CHAR;
      end else begin
         bist_act <= 1'b0;
         hold_q   <= src_char;
      end
   end
endmodule

// File: rtl/enc_bist_seq_chk.sv
module enc_bist_seq_chk #(
   parameter int W     = 9,
   parameter int TAP_B = 5,
   parameter int ERR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chk_en_n,
   input  logic             rx_valid,
   input  logic [W-1:0]     rx_char,
   output logic             locked,
   output logic             mismatch,
   output logic [ERR_W-1:0] errs
);
   localparam logic [ERR_W-1:0] ERR_MAX = '1;

   logic [W-1:0] exp_q;
   logic [W-1:0] base_char;
   logic [W-1:0] succ_char;
   logic         differ;

   // Before lock the successor of the received character seeds the
   // prediction; after lock the prediction walks on by itself.
   assign base_char = locked ? exp_q : rx_char;
   assign differ    = locked && (rx_char != exp_q);

   enc_bist_lfsr_step #(.W(W), .TAP_B(TAP_B)) u_step (
      .cur_char (base_char),
      .nxt_char (succ_char)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked   <= 1'b0;
         mismatch <= 1'b0;
         errs     <= '0;
         exp_q    <= '0;
      end else if (chk_en_n) begin
         locked   <= 1'b0;
         mismatch <= 1'b0;
         errs     <= '0;
      end else if (!rx_valid) begin
         mismatch <= 1'b0;
      end else begin
         locked   <= 1'b1;
         exp_q    <= succ_char;
         mismatch <= differ;
         if (differ && errs != ERR_MAX) errs <= errs + 1'b1;
      end
   end
endmodule

// File: rtl/enc_bist_reg.sv
module enc_bist_reg #(
   parameter int CODE_W = 8,
   parameter int TAP_B  = 5,
   parameter int SEED   = 1,
   parameter int ERR_W  = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bist_en_n,
   input  logic [1:0]          src_sel,
   input  logic [CODE_W:0]     fifo_char,
   input  logic [CODE_W:0]     direct_char,
   input  logic [CODE_W:0]     packer_char,
   input  logic [CODE_W:0]     ctrl_char,
   output logic [CODE_W:0]     enc_char,
   input  logic                chk_en_n,
   input  logic                rx_valid,
   input  logic [CODE_W:0]     rx_char,
   output logic                chk_locked,
   output logic                chk_mismatch,
   output logic [ERR_W-1:0]    chk_errs
);
   localparam int                CHAR_W    = CODE_W + 1;
   localparam logic [CHAR_W-1:0] SEED_ST   = CHAR_W'(SEED);
   localparam logic [CHAR_W-1:0] SEED_CHAR = ~SEED_ST;

   generate
      if (CODE_W < 2 || CODE_W > 30) begin : g_bad_code
         $error("enc_bist_reg: CODE_W out of range");
      end
      if (TAP_B < 1 || TAP_B >= CHAR_W) begin : g_bad_tap
         $error("enc_bist_reg: TAP_B must lie inside the register");
      end
      if (SEED_ST == '0) begin : g_bad_seed
         $error("enc_bist_reg: SEED must be non-zero in the register width");
      end
      if (ERR_W < 1 || ERR_W > 32) begin : g_bad_err
         $error("enc_bist_reg: ERR_W out of range");
      end
   endgenerate

   logic [CHAR_W-1:0] src_pick;
   logic              bist_act;

   enc_bist_src_mux #(.W(CHAR_W)) u_mux (
      .sel      (src_sel),
      .fifo_c   (fifo_char),
      .direct_c (direct_char),
      .packer_c (packer_char),
      .ctrl_c   (ctrl_char),
      .pick     (src_pick)
   );

   enc_bist_hold_reg #(.W(CHAR_W), .TAP_B(TAP_B), .SEED_CHAR(SEED_CHAR)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .bist_en_n (bist_en_n),
      .src_char  (src_pick),
      .hold_q    (enc_char),
      .bist_act  (bist_act)
   );

   enc_bist_seq_chk #(.W(CHAR_W), .TAP_B(TAP_B), .ERR_W(ERR_W)) u_chk (
      .clk      (clk),
      .rst_n    (rst_n),
      .chk_en_n (chk_en_n),
      .rx_valid (rx_valid),
      .rx_char  (rx_char),
      .locked   (chk_locked),
      .mismatch (chk_mismatch),
      .errs     (chk_errs)
   );
endmodule

// File: rtl/enc_bist_reg_sva.sv
module enc_bist_reg_sva #(
   parameter int                CHAR_W    = 9,
   parameter int                ERR_W     = 8,
   parameter logic [CHAR_W-1:0] SEED_CHAR = '1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bist_en_n,
   input logic [1:0]        src_sel,
   input logic [CHAR_W-1:0] fifo_char,
   input logic [CHAR_W-1:0] ctrl_char,
   input logic [CHAR_W-1:0] enc_char,
   input logic              bist_act,
   input logic              chk_en_n,
   input logic              rx_valid,
   input logic              chk_locked,
   input logic              chk_mismatch,
   input logic [ERR_W-1:0]  chk_errs
);
   p_fifo_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bist_en_n && src_sel == 2'd0) |=> enc_char == $past(fifo_char));

   p_ctrl_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bist_en_n && src_sel == 2'd3) |=> enc_char == $past(ctrl_char));

   p_seed_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!bist_en_n && !bist_act) |=> (bist_act && enc_char == SEED_CHAR));

   p_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!bist_en_n && bist_act) |=> enc_char != $past(enc_char));

   p_no_lockup_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bist_act |-> enc_char != '1);

   p_leave_r6: assert property (@(posedge clk) disable iff (!rst_n)
      bist_en_n |=> !bist_act);

   p_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!chk_en_n && rx_valid && !chk_locked) |=> (chk_locked && !chk_mismatch));

   p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!chk_en_n && !rx_valid) |=>
         (!chk_mismatch && $stable(chk_errs) && $stable(chk_locked)));

   p_counted_r9: assert property (@(posedge clk) disable iff (!rst_n)
      chk_mismatch |-> chk_errs != '0);

   p_saturate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!chk_en_n && (&chk_errs)) |=> (&chk_errs));

   p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      chk_en_n |=> (!chk_locked && !chk_mismatch && chk_errs == '0));
endmodule

bind enc_bist_reg enc_bist_reg_sva #(
   .CHAR_W    (CHAR_W),
   .ERR_W     (ERR_W),
   .SEED_CHAR (SEED_CHAR)
) u_sva (
   .clk          (clk),
   .rst_n        (rst_n),
   .bist_en_n    (bist_en_n),
   .src_sel      (src_sel),
   .fifo_char    (fifo_char),
   .ctrl_char    (ctrl_char),
   .enc_char     (enc_char),
   .bist_act     (bist_act),
   .chk_en_n     (chk_en_n),
   .rx_valid     (rx_valid),
   .chk_locked   (chk_locked),
   .chk_mismatch (chk_mismatch),
   .chk_errs     (chk_errs)
);

// File: tb/enc_bist_reg_test.sv
module enc_bist_reg_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bist_en_n = 1'b1;
   logic [1:0] src_sel = 2'd0;
   logic [8:0] fifo_char = '0, direct_char = '0, packer_char = '0, ctrl_char = '0;
   logic [8:0] enc_char;
   logic       chk_en_n = 1'b1;
   logic       rx_valid = 1'b0;
   logic [8:0] rx_char = '0;
   logic       chk_locked, chk_mismatch;
   logic [7:0] chk_errs;

   int errors = 0;
   int checks = 0;

   // behavioural reference state
   int m_char = 0, m_exp = 0, m_errs = 0;
   bit m_bist = 0, m_locked = 0, m_mis = 0;
   bit seen [512];

   always #2 clk = ~clk;

   enc_bist_reg uut (
      .clk(clk), .rst_n(rst_n), .bist_en_n(bist_en_n), .src_sel(src_sel),
      .fifo_char(fifo_char), .direct_char(direct_char),
      .packer_char(packer_char), .ctrl_char(ctrl_char),
      .enc_char(enc_char), .chk_en_n(chk_en_n), .rx_valid(rx_valid),
      .rx_char(rx_char), .chk_locked(chk_locked),
      .chk_mismatch(chk_mismatch), .chk_errs(chk_errs)
   );

   // Successor in the character domain: invert, shift in s8^s4, invert back.
   function automatic int succ(input int c);
      int s, fb;
      s  = c ^ 511;
      fb = ((s >> 8) ^ (s >> 4)) & 1;
      s  = ((s << 1) & 511) | fb;
      return s ^ 511;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_edge();
      int pick;
      if (!bist_en_n) begin
         m_char = m_bist ? succ(m_char) : 9'h1FE;
         m_bist = 1;
      end else begin
         case (src_sel)
            2'd0: pick = fifo_char;
            2'd1: pick = direct_char;
            2'd2: pick = packer_char;
            default: pick = ctrl_char;
         endcase
         m_char = pick;
         m_bist = 0;
      end
      if (chk_en_n) begin
         m_locked = 0; m_mis = 0; m_errs = 0;
      end else if (!rx_valid) begin
         m_mis = 0;
      end else if (!m_locked) begin
         m_locked = 1; m_exp = succ(int'(rx_char)); m_mis = 0;
      end else begin
         m_mis = (int'(rx_char) != m_exp);
         if (m_mis && m_errs < 255) m_errs++;
         m_exp = succ(m_exp);
      end
   endtask

   task automatic compare_all();
      check(int'(enc_char) == m_char, m_bist ? "R4 sequence" : "R2 source load",
            enc_char, m_char);
      check(chk_locked == m_locked, "R7 lock", chk_locked, m_locked);
      check(chk_mismatch == m_mis, "R8 mismatch", chk_mismatch, m_mis);
      check(int'(chk_errs) == m_errs, "R9 count", chk_errs, m_errs);
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
      model_edge();
      compare_all();
   endtask

   task automatic random_sources();
      fifo_char   = 9'($urandom);
      direct_char = 9'($urandom);
      packer_char = 9'($urandom);
      ctrl_char   = 9'($urandom);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      int cnt;
      int seed_at;
      // R1: reset state
      repeat (3) @(posedge clk);
      #1;
      check(enc_char == 9'h000, "R1 reset char", enc_char, 0);
      check(!chk_locked && !chk_mismatch, "R1 reset flags", {chk_locked, chk_mismatch}, 0);
      check(chk_errs == 8'h00, "R1 reset count", chk_errs, 0);
      rst_n = 1'b1;
      tick();

      // R2: normal loads under varied selections
      for (int i = 0; i < 48; i++) begin
         src_sel = 2'(i % 4);
         random_sources();
         tick();
      end

      // R3: entry loads the seed character
      bist_en_n = 1'b0;
      random_sources();
      tick();
      check(enc_char == 9'h1FE, "R3 seed", enc_char, 9'h1FE);

      // R4/R5/R6: one full period with sources churning; loopback to checker
      foreach (seen[k]) seen[k] = 0;
      seen[enc_char] = 1;
      chk_en_n = 1'b0;
      rx_valid = 1'b1;
      seed_at = 0;
      for (int i = 1; i <= 511; i++) begin
         rx_char = 9'(m_char);
         random_sources();
         src_sel = 2'($urandom);
         tick();
         if (i < 511) seen[enc_char] = 1;
         if (enc_char == 9'h1FE && seed_at == 0) seed_at = i;
      end
      check(seed_at == 511, "R4 period", seed_at, 511);
      cnt = 0;
      foreach (seen[k]) if (seen[k]) cnt++;
      check(cnt == 511, "R5 distinct codes", cnt, 511);
      check(!seen[511], "R5 all-ones absent", seen[511], 0);
      check(chk_locked && chk_errs == 0, "R8 clean loopback", chk_errs, 0);

      // R8/R9: a single corrupted character
      rx_char = 9'(m_char ^ 1);
      tick();
      check(chk_mismatch == 1'b1, "R8 injected mismatch", chk_mismatch, 1);
      check(chk_errs == 8'd1, "R9 one error counted", chk_errs, 1);

      // R8: idle cycles hold everything
      rx_valid = 1'b0;
      repeat (3) tick();
      check(chk_errs == 8'd1 && !chk_mismatch, "R8 idle hold", chk_errs, 1);

      // R6: leaving self-test loads the source on the next edge
      bist_en_n   = 1'b0;
      bist_en_n   = 1'b1;
      src_sel     = 2'd1;
      direct_char = 9'h0AB;
      tick();
      check(enc_char == 9'h0AB, "R6 leave self-test", enc_char, 9'h0AB);

      // R9: saturation under a long run of bad characters
      rx_valid = 1'b1;
      rx_char  = 9'h055;
      repeat (300) tick();
      check(chk_errs == 8'd255, "R9 saturation", chk_errs, 255);

      // R10: disabling clears the checker
      chk_en_n = 1'b1;
      tick();
      check(!chk_locked && chk_errs == 0, "R10 clear", chk_errs, 0);

      // R7: relock on an arbitrary first character, then track it
      chk_en_n = 1'b0;
      rx_char  = 9'h123;
      tick();
      check(chk_locked && !chk_mismatch, "R7 lock on first", chk_locked, 1);
      for (int i = 0; i < 20; i++) begin
         rx_char = 9'(m_exp);
         tick();
      end
      check(chk_errs == 0, "R7 tracking after lock", chk_errs, 0);

      // R3: re-entry reseeds
      bist_en_n = 1'b0;
      tick();
      check(enc_char == 9'h1FE, "R3 reseed", enc_char, 9'h1FE);
      repeat (10) tick();

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule